// File: doc/BRIEF.md
# Flash Command Front End with Identifier Readout

This block models the command side of a block-organised flash memory on a system clock. The write strobe and three chip-select pins arrive asynchronously, so they are brought into the clock domain through a synchroniser. A write ends when WE is released or when any chip select drops out, whichever happens first. At that moment the address and data captured during the write are handed to a command decoder. The decoder chooses what a read returns: array data (a fixed placeholder, since array storage is not part of this block), the identifier words, or the status register.

The decoder also holds a lock bit for every block and one master lock bit. The lock state can be read back in identifier mode at fixed offsets. Every lock change is refused while the programming-enable input `vpen_ok` is low. Block lock changes are also refused once the master lock is set, unless `lock_override` is high. A refused command sets error bits in the status register, which a Clear Status command resets.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the read mode is array, every block lock bit and the master lock are 0, and a read returns the placeholder 16'hFFFF.
- R2: A command is accepted only while ce0_n, ce1_n and ce2_n are all low and we_n is low. A WE pulse with any chip select high has no effect.
- R3: A write executes at the first of two events: WE rising, or a chip select rising while WE is still low. It uses the address and data held just before that event. Data driven afterwards is ignored.
- R4: Command 8'h90 selects identifier mode. Word address 0 reads {8'h00, MFR_CODE} and word address 1 reads {8'h00, DEV_CODE}. The defaults are 8'h5A and 8'h3C.
- R5: In identifier mode, word N·0x10000+2 reads {15'b0, lock of block N} and word 3 reads {15'b0, master lock}. Every other offset reads 0. Byte-select bit addr[0] is ignored.
- R6: Command 8'h70 selects status mode, and a read returns {8'h00, SR}. SR bit 7 (ready) is always 1. Command 8'h50 clears SR bits 5, 4, 3 and 1 and leaves the read mode unchanged.
- R7: Command 8'h60 followed by 8'h01 sets the lock of the block that contains the second cycle's address. Command 8'h60 followed by 8'hD0 clears all block locks. After either pair, reads return status.
- R8: Command 8'h60 followed by 8'hF1 sets the master lock. Only reset clears it.
- R9: With vpen_ok low, every lock command is refused and leaves all lock bits unchanged. It sets SR bit 3, plus bit 4 for a set command or bit 5 for a clear command.
- R10: With the master lock set and lock_override low, block lock set or clear is refused. It sets SR bit 1 plus bit 4 (set) or bit 5 (clear). With lock_override high the change is made.
- R11: After 8'h60, an unrecognised second byte sets SR bits 4 and 5 and changes no lock bit.
- R12: Command 8'hFF returns to array mode. An unrecognised single-cycle byte leaves the mode and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we_n | input | 1 | Asynchronous write strobe, active low |
| ce0_n | input | 1 | Chip select 0, active low |
| ce1_n | input | 1 | Chip select 1, active low |
| ce2_n | input | 1 | Chip select 2, active low |
| addr | input | BLK_BITS+BLK_WORD_BITS+1 | Byte address; bit 0 selects the byte |
| din | input | 16 | Write data; the command sits in bits 7:0 |
| vpen_ok | input | 1 | Programming enable level is valid |
| lock_override | input | 1 | Permits block lock changes while the master lock is set |
| dout | output | 16 | Registered read data |

## Verification
The bench builds the 32-block variant, so the address is 22 bits wide and block 31 is the highest block in the map. This lets the bench check that the identifier lock words decode the block number all the way up to the top block. The bench keeps two synchroniser stages. Its pulses are held long enough to cover that latency, so the CE-ended write and the late data change after it can be told apart at the ports.

// File: rtl/flash_cmd_pkg.sv
// Shared encodings for the flash command front end.
// Assumes: commands are carried in the low byte of the write data.
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_e;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_READ_SR    = 8'h70;
    localparam logic [7:0] CMD_CLEAR_SR   = 8'h50;
    localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
    localparam logic [7:0] CMD_LK_BLOCK   = 8'h01;
    localparam logic [7:0] CMD_LK_MASTER  = 8'hF1;
    localparam logic [7:0] CMD_LK_CLEAR   = 8'hD0;

    localparam int SR_READY = 7;
    localparam int SR_CLR   = 5;
    localparam int SR_SET   = 4;
    localparam int SR_VPEN  = 3;
    localparam int SR_PROT  = 1;

    localparam logic [7:0] SR_IDLE = 8'h80;

endpackage

// File: rtl/flash_wr_detect.sv
// Synchronises WE and the three chip selects and detects the end of a write.
// The end of a write is the first of WE rising or a chip select rising.
// Captures address and data on every cycle in which the synchronised write is active.
// Assumes: addr and din are held stable until SYNC_STAGES+1 cycles after the write ends.
module flash_wr_detect #(
    parameter int AW          = 23,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_n,
    input  logic          ce0_n,
    input  logic          ce1_n,
    input  logic          ce2_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_stb,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data
);

    localparam int PINS = 4;

    logic [PINS-1:0] sync_q [SYNC_STAGES];
    logic [PINS-1:0] pins_s;
    logic            active;
    logic            active_q;

    // Synchroniser chain; index 0 samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
        end else begin
            sync_q[0] <= {ce2_n, ce1_n, ce0_n, we_n};
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign pins_s = sync_q[SYNC_STAGES-1];
    assign active = (pins_s[3:1] == 3'b000) && !pins_s[0];

    // Remember the previous write-active state for end detection.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active;
    end

    // Track address and data while the write is active; hold once it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (active) begin
            cap_addr <= addr;
            cap_data <= din;
        end
    end

    assign wr_stb = active_q && !active;

endmodule

// File: rtl/flash_cmd_fsm.sv
// Decodes single and two-cycle commands and keeps read mode, status and lock bits.
// Assumes: one wr_stb pulse per completed write; block number taken from the word address.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLOCKS    = 64,
    parameter int BLK_WORD_BITS = 16,
    parameter int AW            = 23,
    parameter int DW            = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [AW-1:0]         cap_addr,
    input  logic [DW-1:0]         cap_data,
    input  logic                  vpen_ok,
    input  logic                  lock_override,
    output rd_mode_e              mode,
    output logic [7:0]            status,
    output logic [NUM_BLOCKS-1:0] blk_lock,
    output logic                  master_lock
);

    localparam int BLK_BITS = $clog2(NUM_BLOCKS);

    logic                  pend_q;
    logic                  pend_n;
    rd_mode_e              mode_n;
    logic [7:0]            sr_n;
    logic [NUM_BLOCKS-1:0] lk_n;
    logic                  ml_n;
    logic [7:0]            cmd;
    logic [BLK_BITS-1:0]   blk_idx;
    logic                  blk_guard;

    assign cmd       = cap_data[7:0];
    assign blk_idx   = cap_addr[AW-1 -: BLK_BITS];
    assign blk_guard = master_lock && !lock_override;

    // Next-state decode for mode, status and lock bits.
    always_comb begin
        mode_n = mode;
        pend_n = pend_q;
        sr_n   = status;
        lk_n   = blk_lock;
        ml_n   = master_lock;
        if (wr_stb) begin
            if (pend_q) begin
                pend_n = 1'b0;
                mode_n = RM_STATUS;
                case (cmd)
                    CMD_LK_BLOCK: begin
                        if (!vpen_ok) begin
                            sr_n[SR_VPEN] = 1'b1;
                            sr_n[SR_SET]  = 1'b1;
                        end else if (blk_guard) begin
                            sr_n[SR_PROT] = 1'b1;
                            sr_n[SR_SET]  = 1'b1;
                        end else begin
                            lk_n[blk_idx] = 1'b1;
                        end
                    end
                    CMD_LK_MASTER: begin
                        if (!vpen_ok) begin
                            sr_n[SR_VPEN] = 1'b1;
                            sr_n[SR_SET]  = 1'b1;
                        end else begin
                            ml_n = 1'b1;
                        end
                    end
                    CMD_LK_CLEAR: begin
                        if (!vpen_ok) begin
                            sr_n[SR_VPEN] = 1'b1;
                            sr_n[SR_CLR]  = 1'b1;
                        end else if (blk_guard) begin
                            sr_n[SR_PROT] = 1'b1;
                            sr_n[SR_CLR]  = 1'b1;
                        end else begin
                            lk_n = '0;
                        end
                    end
                    default: begin
                        sr_n[SR_SET] = 1'b1;
                        sr_n[SR_CLR] = 1'b1;
                    end
                endcase
            end else begin
                case (cmd)
                    CMD_READ_ARRAY: mode_n = RM_ARRAY;
                    CMD_READ_ID:    mode_n = RM_IDENT;
                    CMD_READ_SR:    mode_n = RM_STATUS;
                    CMD_CLEAR_SR:   sr_n   = SR_IDLE;
                    CMD_LOCK_SETUP: pend_n = 1'b1;
                    default:        ;
                endcase
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode        <= RM_ARRAY;
            pend_q      <= 1'b0;
            status      <= SR_IDLE;
            blk_lock    <= '0;
            master_lock <= 1'b0;
        end else begin
            mode        <= mode_n;
            pend_q      <= pend_n;
            status      <= sr_n;
            blk_lock    <= lk_n;
            master_lock <= ml_n;
        end
    end

endmodule

// File: rtl/flash_id_map.sv
// Identifier address decode: the codes at words 0 and 1, master lock at word 3,
// and per-block lock words at offset 2 of every block.
// Assumes: NUM_BLOCKS is a power of two; word_addr excludes the byte-select bit.
module flash_id_map #(
    parameter int            NUM_BLOCKS    = 64,
    parameter int            BLK_WORD_BITS = 16,
    parameter int            WA_W          = 22,
    parameter logic [7:0]    MFR_CODE      = 8'h5A,
    parameter logic [7:0]    DEV_CODE      = 8'h3C
) (
    input  logic [WA_W-1:0]       word_addr,
    input  logic [NUM_BLOCKS-1:0] blk_lock,
    input  logic                  master_lock,
    output logic [7:0]            id_byte
);

    localparam int BLK_BITS = $clog2(NUM_BLOCKS);

    logic [BLK_WORD_BITS-1:0] offs;
    logic [BLK_BITS-1:0]      blk;

    assign offs = word_addr[BLK_WORD_BITS-1:0];
    assign blk  = word_addr[WA_W-1 -: BLK_BITS];

    // Select the identifier byte for the current word address.
    always_comb begin
        id_byte = 8'h00;
        if (offs == BLK_WORD_BITS'(2)) begin
            id_byte = {7'b0, blk_lock[blk]};
        end else if (blk == '0) begin
            case (offs)
                BLK_WORD_BITS'(0): id_byte = MFR_CODE;
                BLK_WORD_BITS'(1): id_byte = DEV_CODE;
                BLK_WORD_BITS'(3): id_byte = {7'b0, master_lock};
                default:           id_byte = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_front.sv
// Top of the flash command front end: write detection, command decode and a registered read path.
// Assumes: addr is a byte address with bit 0 as byte select; the read address is stable for one clock.
module flash_cmd_front
    import flash_cmd_pkg::*;
#(
    parameter int         NUM_BLOCKS    = 64,
    parameter int         BLK_WORD_BITS = 16,
    parameter int         SYNC_STAGES   = 2,
    parameter logic [7:0] MFR_CODE      = 8'h5A,
    parameter logic [7:0] DEV_CODE      = 8'h3C,
    parameter logic [15:0] ARRAY_FILL   = 16'hFFFF,
    localparam int        BLK_BITS      = $clog2(NUM_BLOCKS),
    localparam int        AW            = BLK_BITS + BLK_WORD_BITS + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_n,
    input  logic          ce0_n,
    input  logic          ce1_n,
    input  logic          ce2_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   din,
    input  logic          vpen_ok,
    input  logic          lock_override,
    output logic [15:0]   dout
);

    localparam int DW   = 16;
    localparam int WA_W = AW - 1;

    logic                  wr_stb;
    logic [AW-1:0]         cap_addr;
    logic [DW-1:0]         cap_data;
    rd_mode_e              mode;
    logic [7:0]            status;
    logic [NUM_BLOCKS-1:0] blk_lock;
    logic                  master_lock;
    logic [7:0]            id_byte;

    flash_wr_detect #(
        .AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)
    ) wr_det_i (
        .clk(clk), .rst_n(rst_n),
        .we_n(we_n), .ce0_n(ce0_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .addr(addr), .din(din),
        .wr_stb(wr_stb), .cap_addr(cap_addr), .cap_data(cap_data)
    );

    flash_cmd_fsm #(
        .NUM_BLOCKS(NUM_BLOCKS), .BLK_WORD_BITS(BLK_WORD_BITS), .AW(AW), .DW(DW)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .cap_addr(cap_addr), .cap_data(cap_data),
        .vpen_ok(vpen_ok), .lock_override(lock_override),
        .mode(mode), .status(status),
        .blk_lock(blk_lock), .master_lock(master_lock)
    );

    flash_id_map #(
        .NUM_BLOCKS(NUM_BLOCKS), .BLK_WORD_BITS(BLK_WORD_BITS), .WA_W(WA_W),
        .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) id_map_i (
        .word_addr(addr[AW-1:1]),
        .blk_lock(blk_lock), .master_lock(master_lock),
        .id_byte(id_byte)
    );

    // Registered read mux selected by the current read mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= ARRAY_FILL;
        end else begin
            case (mode)
                RM_IDENT:  dout <= {8'h00, id_byte};
                RM_STATUS: dout <= {8'h00, status};
                default:   dout <= ARRAY_FILL;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_front_chk.sv
// Assertion checker for flash_cmd_front, attached by bind.
module flash_cmd_front_chk
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLOCKS = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_stb,
    input logic                  vpen_ok,
    input logic                  lock_override,
    input logic [NUM_BLOCKS-1:0] blk_lock,
    input logic                  master_lock,
    input rd_mode_e              mode,
    input logic [7:0]            status,
    input logic [15:0]           dout
);

    // R2
    locks_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(blk_lock) && $stable(master_lock)));

    // R9
    vpen_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !vpen_ok) |=> ($stable(blk_lock) && $stable(master_lock)));

    // R8
    master_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_lock |=> master_lock);

    // R10
    master_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && master_lock && !lock_override) |=> $stable(blk_lock));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != RM_ARRAY) |=> (dout[15:8] == 8'h00));

    // R6
    ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_STATUS) |=> dout[7]);

endmodule

bind flash_cmd_front flash_cmd_front_chk #(.NUM_BLOCKS(NUM_BLOCKS)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
    .vpen_ok(vpen_ok), .lock_override(lock_override),
    .blk_lock(blk_lock), .master_lock(master_lock),
    .mode(mode), .status(status), .dout(dout)
);

// File: tb/flash_cmd_front_tb_top.sv
// Directed bench for flash_cmd_front, 32-block build.
module flash_cmd_front_tb_top;

    localparam int NB = 32;
    localparam int AW = 5 + 16 + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we_n = 1'b1;
    logic          ce0_n = 1'b1;
    logic          ce1_n = 1'b1;
    logic          ce2_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic          vpen_ok = 1'b1;
    logic          lock_override = 1'b0;
    logic [15:0]   dout;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    flash_cmd_front #(.NUM_BLOCKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .we_n(we_n),
        .ce0_n(ce0_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .addr(addr), .din(din), .vpen_ok(vpen_ok),
        .lock_override(lock_override), .dout(dout)
    );

    function automatic logic [AW-1:0] baddr(input int blk, input int offs, input bit b0);
        return {blk[4:0], offs[15:0], b0};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
    endtask

    // Normal write ended by WE rising.
    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = {8'h00, d};
        ce0_n = 1'b0; ce1_n = 1'b0; ce2_n = 1'b0;
        wait_n(2);
        we_n = 1'b0;
        wait_n(4);
        we_n = 1'b1;
        wait_n(4);
        ce0_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1;
        wait_n(4);
    endtask

    // Write ended by ce0 rising while WE is still low; data changes afterwards.
    task automatic bus_write_ce_end(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = {8'h00, d};
        ce0_n = 1'b0; ce1_n = 1'b0; ce2_n = 1'b0;
        wait_n(2);
        we_n = 1'b0;
        wait_n(4);
        ce0_n = 1'b1;
        wait_n(4);
        din = 16'h00D0;
        wait_n(4);
        we_n = 1'b1;
        wait_n(2);
        ce1_n = 1'b1; ce2_n = 1'b1;
        wait_n(4);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        wait_n(3);
        d = dout;
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
        logic [15:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        // R1
        rd_check("R1 array placeholder", baddr(0, 0, 0), 16'hFFFF);
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R1 block0 lock clear", baddr(0, 2, 0), 16'h0000);
        rd_check("R1 block31 lock clear", baddr(31, 2, 0), 16'h0000);
        rd_check("R1 master clear", baddr(0, 3, 0), 16'h0000);
        bus_write(baddr(0, 0, 0), 8'hFF);
    endtask

    task automatic t_select();
        // R2: ce2 held high
        @(negedge clk);
        addr = baddr(0, 0, 0); din = 16'h0090;
        ce0_n = 1'b0; ce1_n = 1'b0; ce2_n = 1'b1;
        wait_n(2); we_n = 1'b0; wait_n(4); we_n = 1'b1; wait_n(3);
        ce0_n = 1'b1; ce1_n = 1'b1; wait_n(4);
        rd_check("R2 deselected write ignored", baddr(0, 0, 0), 16'hFFFF);
    endtask

    task automatic t_ident();
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R4 manufacturer code", baddr(0, 0, 0), 16'h005A);
        rd_check("R5 byte select ignored", baddr(0, 0, 1), 16'h005A);
        rd_check("R4 device code", baddr(0, 1, 0), 16'h003C);
        rd_check("R5 reserved offset", baddr(0, 4, 0), 16'h0000);
        rd_check("R5 reserved offset other block", baddr(3, 0, 0), 16'h0000);
    endtask

    task automatic t_block_lock();
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write(baddr(5, 16'h1234, 0), 8'h01);
        rd_check("R7 status after lock", baddr(0, 0, 0), 16'h0080);
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R7 block5 locked", baddr(5, 2, 0), 16'h0001);
        rd_check("R7 block4 untouched", baddr(4, 2, 0), 16'h0000);
    endtask

    task automatic t_ce_end();
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write_ce_end(baddr(31, 16'h00AB, 0), 8'h01);
        bus_write(baddr(0, 0, 0), 8'h90);
        // R3: lock set, not cleared by the later D0 data
        rd_check("R3 block31 locked via CE end", baddr(31, 2, 0), 16'h0001);
        rd_check("R3 block5 still locked", baddr(5, 2, 0), 16'h0001);
    endtask

    task automatic t_clear();
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write(baddr(9, 0, 0), 8'hD0);
        rd_check("R7 status after clear", baddr(0, 0, 0), 16'h0080);
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R7 block5 cleared", baddr(5, 2, 0), 16'h0000);
        rd_check("R7 block31 cleared", baddr(31, 2, 0), 16'h0000);
    endtask

    task automatic t_vpen();
        vpen_ok = 1'b0;
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write(baddr(2, 0, 0), 8'h01);
        rd_check("R9 set refused status", baddr(0, 0, 0), 16'h0098);
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R9 block2 not locked", baddr(2, 2, 0), 16'h0000);
        bus_write(baddr(0, 0, 0), 8'h50);
        bus_write(baddr(0, 0, 0), 8'h70);
        rd_check("R6 status cleared", baddr(0, 0, 0), 16'h0080);
        vpen_ok = 1'b1;
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write(baddr(2, 0, 0), 8'h01);
        vpen_ok = 1'b0;
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write(baddr(0, 0, 0), 8'hD0);
        rd_check("R9 clear refused status", baddr(0, 0, 0), 16'h00A8);
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R9 block2 kept", baddr(2, 2, 0), 16'h0001);
        vpen_ok = 1'b1;
    endtask

    task automatic t_seq_err();
        bus_write(baddr(0, 0, 0), 8'h50);
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write(baddr(2, 0, 0), 8'h22);
        rd_check("R11 sequence error status", baddr(0, 0, 0), 16'h00B0);
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R11 block2 kept", baddr(2, 2, 0), 16'h0001);
    endtask

    task automatic t_unknown();
        bus_write(baddr(0, 0, 0), 8'h50);
        bus_write(baddr(0, 0, 0), 8'h70);
        bus_write(baddr(0, 0, 0), 8'h33);
        rd_check("R12 unknown byte ignored", baddr(0, 0, 0), 16'h0080);
        bus_write(baddr(0, 0, 0), 8'hFF);
        rd_check("R12 back to array", baddr(0, 0, 0), 16'hFFFF);
    endtask

    task automatic t_master();
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write(baddr(0, 0, 0), 8'hF1);
        rd_check("R8 status after master", baddr(0, 0, 0), 16'h0080);
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R8 master set", baddr(0, 3, 0), 16'h0001);
        lock_override = 1'b0;
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write(baddr(7, 0, 0), 8'h01);
        rd_check("R10 guarded set status", baddr(0, 0, 0), 16'h0092);
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write(baddr(0, 0, 0), 8'hD0);
        rd_check("R10 guarded clear status", baddr(0, 0, 0), 16'h00B2);
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R10 block7 not locked", baddr(7, 2, 0), 16'h0000);
        rd_check("R10 block2 kept", baddr(2, 2, 0), 16'h0001);
        bus_write(baddr(0, 0, 0), 8'h50);
        lock_override = 1'b1;
        bus_write(baddr(0, 0, 0), 8'h60);
        bus_write(baddr(7, 0, 0), 8'h01);
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R10 override lets set", baddr(7, 2, 0), 16'h0001);
        lock_override = 1'b0;
        do_reset();
        bus_write(baddr(0, 0, 0), 8'h90);
        rd_check("R8 master cleared by reset", baddr(0, 3, 0), 16'h0000);
        rd_check("R1 block7 cleared by reset", baddr(7, 2, 0), 16'h0000);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Test sequence.
    initial begin
        do_reset();
        t_reset();
        t_select();
        t_ident();
        t_block_lock();
        t_ce_end();
        t_clear();
        t_vpen();
        t_seq_err();
        t_unknown();
        t_master();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule